// File: doc/BRIEF.md
# Vectored Pending Interrupt Controller

This block gathers interrupt requests from the on-chip event sources of a small microcontroller: a bus-reset event, a fast periodic tick, a slow periodic tick, a set of endpoint events, a group of general-purpose pins and a serial controller. Each request is held in its own sticky pending flag. A flag stays set when its source is masked and is cleared only when the CPU takes that interrupt or when the block is reset.

Firmware controls masking through a write-only configuration port with two registers. The first register holds one enable bit for each source group and a master enable. The second holds one enable bit for each endpoint. When at least one pending source is enabled and the master enable is set, the block raises an interrupt request to the CPU. It also presents the even program address of the winning source. The lowest address wins. When the CPU acknowledges, only the presented source's flag is cleared, and the master enable drops. Firmware must set the master enable again before the next interrupt can be taken.

Top module: `vpic_top`

## Requirements
- R1: After reset all pending flags and both enable registers are zero, `irq` is low and `irq_vector` is 0x0000.
- R2: A one-cycle request pulse sets that source's pending flag even while the source is masked. The flag is kept, and `irq` rises in the cycle after the enabling write.
- R3: The source vectors are fixed even addresses: bus reset 0x0002, fast tick 0x0004, slow tick 0x0006, endpoint k at 0x0008+2k, the pin group at 0x0008+2·EP_N, and the serial controller 2 above that (0x000E and 0x0010 with EP_N=3).
- R4: When several enabled sources are pending, the lowest vector address is presented.
- R5: An acknowledge taken while `irq` is high clears only the pending flag of the source whose vector is presented in that cycle.
- R6: Taking an interrupt clears the master enable (global register bit 7), so `irq` stays low until firmware writes that bit again.
- R7: An endpoint source is enabled only when the endpoint group bit (global bit 3) and its own bit k of the endpoint register are both set.
- R8: All general-purpose pins share one pending flag (global enable bit 4). Requests on several pins give one interrupt, and one acknowledge clears them all.
- R9: A new request that arrives in the same cycle as the acknowledge of its own source leaves the flag set.
- R10: While `irq` is low, `irq_vector` reads 0x0000.
- R11: An acknowledge while `irq` is low changes no pending flag. The remaining group enables are global bits 0 (bus reset), 1 (fast tick), 2 (slow tick) and 5 (serial). `cfg_sel` 0 selects the global register and 1 selects the endpoint register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset_evt | input | 1 | Bus-reset request pulse |
| tick_fast | input | 1 | Fast periodic timer pulse |
| tick_slow | input | 1 | Slow periodic timer pulse |
| ep_evt | input | EP_N | Endpoint request pulses |
| gpio_evt | input | GPIO_N | Per-pin request pulses, merged into one source |
| serial_evt | input | 1 | Serial controller request pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 global, 1 endpoint |
| cfg_wdata | input | 8 | Configuration write data |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq | output | 1 | Interrupt request to the CPU |
| irq_vector | output | VEC_W | Vector address of the presented source |

## Verification
The assertions check the per-cycle rules on every cycle. A pending flag holds until it is cleared, a clear without a new request drops it, and a new request always sets it. The master enable falls after every taken interrupt. At most one source is granted. The vector is even and non-zero while `irq` is high, and zero while `irq` is low. An idle acknowledge leaves the flags unchanged. Only the bench scenarios can show the ordering that spans several cycles: masked requests that surface after a later write, priority draining one source per acknowledge, the two-level endpoint mask, merging of the pins into one flag, and the absolute vector value of each source.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  // bit positions of the global enable register
  localparam int GLB_BUSRST = 0;
  localparam int GLB_FAST   = 1;
  localparam int GLB_SLOW   = 2;
  localparam int GLB_EPGRP  = 3;
  localparam int GLB_GPIO   = 4;
  localparam int GLB_SERIAL = 5;
  localparam int GLB_MASTER = 7;

  typedef enum logic {
    CFG_GLOBAL = 1'b0,
    CFG_ENDPT  = 1'b1
  } cfg_sel_e;

  // vector address of source index idx (index 0 sits just above the reset entry)
  function automatic int unsigned vec_of(int unsigned idx);
    return (idx + 1) * 2;
  endfunction

endpackage

// File: rtl/vpic_pending.sv
module vpic_pending #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> pend_o[i]);
  end

endmodule

// File: rtl/vpic_enables.sv
module vpic_enables
  import vpic_pkg::*;
#(
  parameter int EP_N = 3,
  parameter int NSRC = 5 + EP_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic            take_i,
  output logic [NSRC-1:0] src_en_o,
  output logic            master_o
);

  localparam int EP_LO = 3;
  localparam int GPIO_IDX = EP_LO + EP_N;

  logic [7:0]      glb_q;
  logic [EP_N-1:0] ep_q;
  logic            wr_glb, wr_ep;

  assign wr_glb = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_GLOBAL);
  assign wr_ep  = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_ENDPT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_q <= '0;
      ep_q  <= '0;
    end else begin
      if (wr_glb) glb_q <= cfg_wdata;
      if (take_i) glb_q[GLB_MASTER] <= 1'b0;
      if (wr_ep)  ep_q <= cfg_wdata[EP_N-1:0];
    end
  end

  assign master_o = glb_q[GLB_MASTER];

  for (genvar i = 0; i < NSRC; i++) begin : g_en
    if (i == 0) begin : g_bus
      assign src_en_o[i] = glb_q[GLB_BUSRST];
    end else if (i == 1) begin : g_fast
      assign src_en_o[i] = glb_q[GLB_FAST];
    end else if (i == 2) begin : g_slow
      assign src_en_o[i] = glb_q[GLB_SLOW];
    end else if (i < GPIO_IDX) begin : g_ep
      assign src_en_o[i] = glb_q[GLB_EPGRP] && ep_q[i-EP_LO];
    end else if (i == GPIO_IDX) begin : g_gpio
      assign src_en_o[i] = glb_q[GLB_GPIO];
    end else begin : g_ser
      assign src_en_o[i] = glb_q[GLB_SERIAL];
    end
  end

  // R6
  master_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !master_o);

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int VEC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_i,
  input  logic             master_i,
  output logic [NSRC-1:0]  grant_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [IDX_W-1:0] sel_idx;
  logic             found;

  always_comb begin
    sel_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && !found) begin
        found   = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign irq_o   = found && master_i;
  assign grant_o = irq_o ? (NSRC'(1) << sel_idx) : '0;
  assign vec_o   = irq_o ? VEC_W'(vec_of(32'(sel_idx))) : '0;

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R10
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0));

endmodule

// File: rtl/vpic_top.sv
module vpic_top #(
  parameter int EP_N   = 3,
  parameter int GPIO_N = 4,
  parameter int VEC_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset_evt,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [EP_N-1:0]  ep_evt,
  input  logic [GPIO_N-1:0] gpio_evt,
  input  logic             serial_evt,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_wdata,
  input  logic             irq_ack,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vector
);

  localparam int NSRC = 5 + EP_N;

  logic [NSRC-1:0] src_req, pend, src_en, grant, clr;
  logic            master, take;

  // source order fixes priority and vector address
  assign src_req = {serial_evt, |gpio_evt, ep_evt, tick_slow, tick_fast, bus_reset_evt};
  assign take    = irq_ack && irq;
  assign clr     = take ? grant : '0;

  vpic_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(src_req), .clr_i(clr), .pend_o(pend)
  );

  vpic_enables #(.EP_N(EP_N), .NSRC(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .take_i(take), .src_en_o(src_en), .master_o(master)
  );

  vpic_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(pend & src_en), .master_i(master),
    .grant_o(grant), .irq_o(irq), .vec_o(irq_vector)
  );

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq && (src_req == '0)) |=> $stable(pend));
  // R3
  vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!irq_vector[0] && (irq_vector != '0)));

endmodule

// File: tb/tb_vpic_top.sv
module tb_vpic_top;
  localparam int CLK_PERIOD = 10;
  localparam int EP_N = 3;
  localparam int GPIO_N = 4;
  localparam int VEC_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset_evt = 0, tick_fast = 0, tick_slow = 0, serial_evt = 0;
  logic [EP_N-1:0] ep_evt = '0;
  logic [GPIO_N-1:0] gpio_evt = '0;
  logic cfg_we = 0, cfg_sel = 0, irq_ack = 0;
  logic [7:0] cfg_wdata = '0;
  logic irq;
  logic [VEC_W-1:0] irq_vector;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  vpic_top #(.EP_N(EP_N), .GPIO_N(GPIO_N), .VEC_W(VEC_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_reset_evt(bus_reset_evt), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .ep_evt(ep_evt), .gpio_evt(gpio_evt), .serial_evt(serial_evt),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .irq_ack(irq_ack),
    .irq(irq), .irq_vector(irq_vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected vector from the requirement's address map
  function automatic int exp_vec(string name, int k);
    case (name)
      "bus":    return 2;
      "fast":   return 4;
      "slow":   return 6;
      "ep":     return 8 + 2*k;
      "gpio":   return 8 + 2*EP_N;
      default:  return 10 + 2*EP_N;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // each stimulus is applied for one edge; outputs are sampled at the following negedge
  task automatic pulse(logic b, logic f, logic s, logic [EP_N-1:0] e, logic [GPIO_N-1:0] g, logic sr);
    bus_reset_evt = b; tick_fast = f; tick_slow = s; ep_evt = e; gpio_evt = g; serial_evt = sr;
    @(negedge clk);
    bus_reset_evt = 0; tick_fast = 0; tick_slow = 0; ep_evt = '0; gpio_evt = '0; serial_evt = 0;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ack();
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
  endtask

  task automatic t_reset();
    check("R1 irq", irq, 0);
    check("R1 vector", irq_vector, 0);
    wr(0, 8'h80);
    check("R1 no pending after reset", irq, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_masked_latch();
    pulse(0, 1, 0, '0, '0, 0);
    check("R2 masked irq", irq, 0);
    repeat (3) @(negedge clk);
    wr(0, 8'h82);
    check("R2 irq after enable", irq, 1);
    check("R3 fast vector", irq_vector, exp_vec("fast", 0));
    ack();
    check("R6 irq after ack", irq, 0);
    check("R10 vector idle", irq_vector, 0);
    wr(0, 8'h82);
    check("R5 fast cleared", irq, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_priority();
    pulse(0, 0, 0, '0, '0, 1);
    pulse(0, 0, 1, '0, '0, 0);
    pulse(1, 0, 0, '0, '0, 0);
    wr(0, 8'hBF);
    check("R4 bus first", irq_vector, exp_vec("bus", 0));
    ack();
    check("R6 master dropped", irq, 0);
    wr(0, 8'hBF);
    check("R5 slow still pending", irq_vector, exp_vec("slow", 0));
    ack(); wr(0, 8'hBF);
    check("R3 serial vector", irq_vector, exp_vec("serial", 0));
    ack(); wr(0, 8'hBF);
    check("R5 all drained", irq, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_endpoint();
    wr(0, 8'h88);
    pulse(0, 0, 0, 3'b010, '0, 0);
    check("R7 ep bit off", irq, 0);
    wr(1, 8'h02);
    check("R7 ep both on", irq, 1);
    check("R3 ep1 vector", irq_vector, exp_vec("ep", 1));
    wr(0, 8'h80);
    check("R7 group off", irq, 0);
    wr(0, 8'h88);
    ack();
    wr(0, 8'h88);
    check("R5 ep cleared", irq, 0);
    wr(1, 8'h00); wr(0, 8'h00);
  endtask

  task automatic t_gpio();
    wr(0, 8'h90);
    pulse(0, 0, 0, '0, 4'b0101, 0);
    check("R8 merged irq", irq, 1);
    check("R8 gpio vector", irq_vector, exp_vec("gpio", 0));
    ack(); wr(0, 8'h90);
    check("R8 one ack clears group", irq, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_collide();
    wr(0, 8'h82);
    pulse(0, 1, 0, '0, '0, 0);
    check("R9 setup", irq_vector, exp_vec("fast", 0));
    irq_ack = 1; tick_fast = 1;
    @(negedge clk);
    irq_ack = 0; tick_fast = 0;
    check("R6 master dropped on collide", irq, 0);
    wr(0, 8'h82);
    check("R9 request kept", irq, 1);
    ack(); wr(0, 8'h00);
  endtask

  task automatic t_idle_ack();
    wr(0, 8'h80);
    pulse(0, 0, 1, '0, '0, 0);
    check("R11 masked", irq, 0);
    ack();
    wr(0, 8'h84);
    check("R11 pending survived", irq, 1);
    check("R11 slow vector", irq_vector, exp_vec("slow", 0));
    ack(); wr(0, 8'h00);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked_latch();
    t_priority();
    t_endpoint();
    t_gpio();
    t_collide();
    t_idle_ack();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule